// File: doc/BRIEF.md
# Per-Sample In-Flight Quad Scoreboard

This block sits between the rasterizer and shader issue and stops two quads from shading the same sample at once. Each request names a quad cell on a small screen grid, counted in quad units, and gives a coverage mask with one bit per sample of each of the four pixels. The block keeps one busy bit for every sample of every quad cell. A request goes out only when none of the samples it would write is busy. In that same cycle the block marks those samples busy and gives the issued quad a tag.

When the shader for a tag completes, the retire port returns that tag and the block clears the bits it stored for it. The bits of other quads are not touched. Each request picks its tracking granularity. In per-sample mode, quads that share a pixel but cover different samples of it can be in flight together. In per-pixel mode, any covered sample widens to the whole pixel, so quads that touch the same pixel are serialized. The busy state always tracks every sample and is never given up, so a request also waits when no tag is free.

Top module: `qsb_scoreboard`

## Requirements
- R1: After reset no sample is busy and all tags are free. The first request is accepted at once and gets tag 0.
- R2: A request that covers any busy sample of its quad cell is not accepted: in_ready_o and iss_valid_o are low in that cycle.
- R3: In per-sample mode (in_mode_i=0) the issued mask equals the request mask. A quad that covers only idle samples of a pixel is accepted even while other samples of that pixel are busy. Mask bit p*NSAMP+s is sample s of pixel p.
- R4: In per-pixel mode (in_mode_i=1) every pixel with at least one covered sample is widened to all NSAMP of its samples. The widened mask is what gets checked, marked and shown on iss_mask_o.
- R5: The check and the marking happen in the issue cycle. A request in the very next cycle that covers any of the newly marked samples stalls.
- R6: A retire of an allocated tag clears exactly the bits that were stored for that tag. Bits held by other tags stay busy.
- R7: A retire takes effect before the check in the same cycle. A request that conflicts only with the tag being retired is accepted in that cycle and may reuse the freed tag.
- R8: While a request is stalled the block issues nothing and changes no tracking state except through retire. A later request cannot overtake it.
- R9: The lowest-numbered free tag is assigned. When all NTAG tags are in use, a request stalls even if it has no sample conflict.
- R10: A retire that names a tag that is not allocated has no effect.
- R11: Busy bits of different quad cells are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | A request is presented |
| in_qx_i | input | $clog2(QX) | Quad cell column |
| in_qy_i | input | $clog2(QY) | Quad cell row |
| in_mask_i | input | 4*NSAMP | Coverage, bit p*NSAMP+s |
| in_mode_i | input | 1 | 0 per-sample, 1 per-pixel tracking |
| in_ready_o | output | 1 | The request can be accepted this cycle |
| iss_valid_o | output | 1 | A quad is issued this cycle |
| iss_tag_o | output | $clog2(NTAG) | Tag given to the issued quad |
| iss_qx_o | output | $clog2(QX) | Column of the issued quad |
| iss_qy_o | output | $clog2(QY) | Row of the issued quad |
| iss_mask_o | output | 4*NSAMP | Mask marked busy for the issued quad |
| ret_valid_i | input | 1 | A shader completion is reported |
| ret_tag_i | input | $clog2(NTAG) | Tag of the completed quad |

## Verification
The bench drives quads that share a pixel but split its samples. A design that checks only at pixel level would stall the second quad. It also checks that a per-pixel request blocks a later per-sample request on a different sample of that pixel, which fails if the widened mask is not the one stored. A retire and a conflicting request arrive in the same cycle: a design that checks before clearing stalls there, and one that clears after setting would lose the new marking. Further cases fill every tag to force a tag stall, retire one quad of two sharing a cell to catch over-clearing, and retire an unallocated tag to catch a ghost clear.

// File: rtl/qsb_pkg.sv
package qsb_pkg;
  localparam int unsigned PIX_PER_QUAD = 4;

  typedef enum logic {
    TRACK_SAMPLE = 1'b0,
    TRACK_PIXEL  = 1'b1
  } track_mode_e;
endpackage

// File: rtl/qsb_mask_expand.sv
module qsb_mask_expand #(
  parameter int unsigned NSAMP = 4,
  localparam int unsigned QBITS = qsb_pkg::PIX_PER_QUAD * NSAMP
) (
  input  logic [QBITS-1:0] mask_i,
  input  logic             pixel_mode_i,
  output logic [QBITS-1:0] mask_o
);
  for (genvar p = 0; p < int'(qsb_pkg::PIX_PER_QUAD); p++) begin : g_pix
    logic any_cov;
    assign any_cov = |mask_i[p*NSAMP +: NSAMP];
    assign mask_o[p*NSAMP +: NSAMP] = pixel_mode_i ? {NSAMP{any_cov}}
                                                   : mask_i[p*NSAMP +: NSAMP];
  end
endmodule

// File: rtl/qsb_tag_table.sv
module qsb_tag_table #(
  parameter int unsigned NTAG  = 8,
  parameter int unsigned LW    = 6,
  parameter int unsigned QBITS = 16,
  localparam int unsigned TW   = (NTAG > 1) ? $clog2(NTAG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_en_i,
  input  logic [LW-1:0]    alloc_loc_i,
  input  logic [QBITS-1:0] alloc_mask_i,
  input  logic             ret_valid_i,
  input  logic [TW-1:0]    ret_tag_i,
  output logic             free_any_o,
  output logic [TW-1:0]    free_tag_o,
  output logic             clr_en_o,
  output logic [LW-1:0]    clr_loc_o,
  output logic [QBITS-1:0] clr_mask_o
);
  logic [NTAG-1:0]  valid_q;
  logic [LW-1:0]    loc_q  [NTAG];
  logic [QBITS-1:0] mask_q [NTAG];
  logic [NTAG-1:0]  avail;

  // retire of a live tag only
  assign clr_en_o   = ret_valid_i && valid_q[ret_tag_i];
  assign clr_loc_o  = loc_q[ret_tag_i];
  assign clr_mask_o = mask_q[ret_tag_i];

  for (genvar i = 0; i < int'(NTAG); i++) begin : g_avail
    assign avail[i] = !valid_q[i] || (clr_en_o && ret_tag_i == TW'(i));
  end

  always_comb begin
    free_any_o = 1'b0;
    free_tag_o = '0;
    for (int i = int'(NTAG) - 1; i >= 0; i--) begin
      if (avail[i]) begin
        free_any_o = 1'b1;
        free_tag_o = TW'(i);
      end
    end
  end

  for (genvar i = 0; i < int'(NTAG); i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        loc_q[i]   <= '0;
        mask_q[i]  <= '0;
      end else if (alloc_en_i && free_tag_o == TW'(i)) begin
        valid_q[i] <= 1'b1;
        loc_q[i]   <= alloc_loc_i;
        mask_q[i]  <= alloc_mask_i;
      end else if (clr_en_o && ret_tag_i == TW'(i)) begin
        valid_q[i] <= 1'b0;
      end
    end
  end

  a_r9_alloc_only_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |-> free_any_o);

  // R8, R10: with no alloc and no live retire the table must hold
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_en_i && !clr_en_o) |=> $stable(valid_q));

  a_r6_retire_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_o && !(alloc_en_i && free_tag_o == ret_tag_i)) |=> !valid_q[$past(ret_tag_i)]);
endmodule

// File: rtl/qsb_busy_array.sv
module qsb_busy_array #(
  parameter int unsigned NLOC  = 64,
  parameter int unsigned QBITS = 16,
  localparam int unsigned LW   = (NLOC > 1) ? $clog2(NLOC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LW-1:0]    rd_loc_i,
  output logic [QBITS-1:0] rd_busy_o,
  input  logic             clr_en_i,
  input  logic [LW-1:0]    clr_loc_i,
  input  logic [QBITS-1:0] clr_mask_i,
  input  logic             set_en_i,
  input  logic [LW-1:0]    set_loc_i,
  input  logic [QBITS-1:0] set_mask_i
);
  logic [QBITS-1:0] busy_q [NLOC];
  logic [QBITS-1:0] rd_clr;

  // same-cycle retire is seen by the check
  assign rd_clr    = (clr_en_i && clr_loc_i == rd_loc_i) ? clr_mask_i : '0;
  assign rd_busy_o = busy_q[rd_loc_i] & ~rd_clr;

  for (genvar l = 0; l < int'(NLOC); l++) begin : g_loc
    logic [QBITS-1:0] clr_l, set_l;
    assign clr_l = (clr_en_i && clr_loc_i == LW'(l)) ? clr_mask_i : '0;
    assign set_l = (set_en_i && set_loc_i == LW'(l)) ? set_mask_i : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) busy_q[l] <= '0;
      else if (clr_en_i || set_en_i) busy_q[l] <= (busy_q[l] & ~clr_l) | set_l;
    end
  end

  a_r5_no_double_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |-> ((busy_q[set_loc_i]
                   & ~((clr_en_i && clr_loc_i == set_loc_i) ? clr_mask_i : '0))
                  & set_mask_i) == '0);

  a_r6_bits_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !(set_en_i && set_loc_i == clr_loc_i))
      |=> (busy_q[$past(clr_loc_i)] & $past(clr_mask_i)) == '0);

  a_r5_bits_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> (busy_q[$past(set_loc_i)] & $past(set_mask_i)) == $past(set_mask_i));
endmodule

// File: rtl/qsb_scoreboard.sv
module qsb_scoreboard #(
  parameter int unsigned QX    = 8,
  parameter int unsigned QY    = 8,
  parameter int unsigned NSAMP = 4,
  parameter int unsigned NTAG  = 8,
  localparam int unsigned QBITS = qsb_pkg::PIX_PER_QUAD * NSAMP,
  localparam int unsigned NLOC  = QX * QY,
  localparam int unsigned XW    = (QX > 1) ? $clog2(QX) : 1,
  localparam int unsigned YW    = (QY > 1) ? $clog2(QY) : 1,
  localparam int unsigned LW    = (NLOC > 1) ? $clog2(NLOC) : 1,
  localparam int unsigned TW    = (NTAG > 1) ? $clog2(NTAG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [XW-1:0]    in_qx_i,
  input  logic [YW-1:0]    in_qy_i,
  input  logic [QBITS-1:0] in_mask_i,
  input  logic             in_mode_i,
  output logic             in_ready_o,
  output logic             iss_valid_o,
  output logic [TW-1:0]    iss_tag_o,
  output logic [XW-1:0]    iss_qx_o,
  output logic [YW-1:0]    iss_qy_o,
  output logic [QBITS-1:0] iss_mask_o,
  input  logic             ret_valid_i,
  input  logic [TW-1:0]    ret_tag_i
);
  import qsb_pkg::*;

  logic [LW-1:0]    in_loc;
  logic [QBITS-1:0] exp_mask, rd_busy, clr_mask;
  logic [LW-1:0]    clr_loc;
  logic             clr_en, free_any, conflict;
  logic [TW-1:0]    free_tag;

  assign in_loc = LW'(in_qy_i) * LW'(QX) + LW'(in_qx_i);

  qsb_mask_expand #(.NSAMP(NSAMP)) u_expand (
    .mask_i       (in_mask_i),
    .pixel_mode_i (in_mode_i == TRACK_PIXEL),
    .mask_o       (exp_mask)
  );

  qsb_tag_table #(.NTAG(NTAG), .LW(LW), .QBITS(QBITS)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_en_i   (iss_valid_o),
    .alloc_loc_i  (in_loc),
    .alloc_mask_i (exp_mask),
    .ret_valid_i  (ret_valid_i),
    .ret_tag_i    (ret_tag_i),
    .free_any_o   (free_any),
    .free_tag_o   (free_tag),
    .clr_en_o     (clr_en),
    .clr_loc_o    (clr_loc),
    .clr_mask_o   (clr_mask)
  );

  qsb_busy_array #(.NLOC(NLOC), .QBITS(QBITS)) u_busy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_loc_i   (in_loc),
    .rd_busy_o  (rd_busy),
    .clr_en_i   (clr_en),
    .clr_loc_i  (clr_loc),
    .clr_mask_i (clr_mask),
    .set_en_i   (iss_valid_o),
    .set_loc_i  (in_loc),
    .set_mask_i (exp_mask)
  );

  assign conflict    = |(rd_busy & exp_mask);
  assign in_ready_o  = free_any && !conflict;
  assign iss_valid_o = in_valid_i && in_ready_o;
  assign iss_tag_o   = free_tag;
  assign iss_qx_o    = in_qx_i;
  assign iss_qy_o    = in_qy_i;
  assign iss_mask_o  = exp_mask;

  a_r11_loc_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (int'(in_qx_i) < int'(QX) && int'(in_qy_i) < int'(QY)));

  a_r3_sample_mask_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && in_mode_i == TRACK_SAMPLE) |-> iss_mask_o == in_mask_i);

  a_r4_pixel_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> (iss_mask_o & in_mask_i) == in_mask_i);
endmodule

// File: tb/tb_qsb_scoreboard.sv
module tb_qsb_scoreboard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_qx = '0, in_qy = '0;
  logic [15:0] in_mask = '0;
  logic        in_mode = 1'b0;
  logic        ret_valid = 1'b0;
  logic [2:0]  ret_tag = '0;
  logic        in_ready, iss_valid;
  logic [2:0]  iss_tag, iss_qx, iss_qy;
  logic [15:0] iss_mask;

  int n_chk = 0, n_err = 0;
  logic        s_rdy, s_iv;
  logic [2:0]  s_tag;
  logic [15:0] s_mask;

  always #4 clk = ~clk;

  qsb_scoreboard dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_qx_i(in_qx),
    .in_qy_i(in_qy), .in_mask_i(in_mask), .in_mode_i(in_mode),
    .in_ready_o(in_ready), .iss_valid_o(iss_valid), .iss_tag_o(iss_tag),
    .iss_qx_o(iss_qx), .iss_qy_o(iss_qy), .iss_mask_o(iss_mask),
    .ret_valid_i(ret_valid), .ret_tag_i(ret_tag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample before posedge, release after
  task automatic step(input logic iv, input int x, input int y, input logic [15:0] m,
                      input logic md, input logic rv, input int rt);
    @(negedge clk);
    in_valid = iv; in_qx = 3'(x); in_qy = 3'(y); in_mask = m; in_mode = md;
    ret_valid = rv; ret_tag = 3'(rt);
    #1;
    s_rdy = in_ready; s_iv = iss_valid; s_tag = iss_tag; s_mask = iss_mask;
    @(posedge clk); #1;
    in_valid = 1'b0; ret_valid = 1'b0;
  endtask

  task automatic req(input int x, input int y, input logic [15:0] m, input logic md);
    step(1'b1, x, y, m, md, 1'b0, 0);
  endtask

  task automatic retire(input int t);
    step(1'b0, 0, 0, '0, 1'b0, 1'b1, t);
  endtask

  task automatic t_reset;
    req(0, 0, 16'hFFFF, 1'b0);
    chk("R1 ready after reset", s_iv, 1);
    chk("R1 first tag", s_tag, 0);
    retire(0);
  endtask

  task automatic t_conflict;
    req(1, 1, 16'h0001, 1'b0);
    chk("R1 issue", s_iv, 1);
    req(1, 1, 16'h0003, 1'b0);
    chk("R5 next-cycle conflict stalls", s_rdy, 0);
    chk("R2 no issue on conflict", s_iv, 0);
    for (int k = 0; k < 3; k++) begin
      req(1, 1, 16'h0001, 1'b0);
      chk("R8 held request stays stalled", s_iv, 0);
    end
    req(1, 1, 16'h0002, 1'b0);
    chk("R3 disjoint sample issues", s_iv, 1);
    chk("R9 tag after held stall", s_tag, 1);
    retire(0); retire(1);
  endtask

  task automatic t_sample_share;
    req(2, 2, 16'h0003, 1'b0);
    chk("R3 first half", s_iv, 1);
    req(2, 2, 16'h000C, 1'b0);
    chk("R3 other samples same pixel", s_iv, 1);
    chk("R3 mask unchanged", s_mask, 16'h000C);
    req(2, 2, 16'h00F0, 1'b0);
    chk("R3 neighbour pixel", s_tag, 2);
    retire(0); retire(1); retire(2);
  endtask

  task automatic t_pixel;
    req(2, 0, 16'h0001, 1'b1);
    chk("R4 pixel issue", s_iv, 1);
    chk("R4 widened mask", s_mask, 16'h000F);
    req(2, 0, 16'h0004, 1'b0);
    chk("R4 widened pixel blocks other sample", s_iv, 0);
    req(2, 0, 16'h0010, 1'b1);
    chk("R4 other pixel issues", s_iv, 1);
    chk("R4 widened second", s_mask, 16'h00F0);
    retire(0);
    req(2, 0, 16'h0004, 1'b0);
    chk("R6 freed pixel issues", s_iv, 1);
    chk("R9 lowest free tag", s_tag, 0);
    retire(0); retire(1);
  endtask

  task automatic t_partial_retire;
    req(3, 3, 16'h00FF, 1'b0);
    req(3, 3, 16'hFF00, 1'b0);
    chk("R6 second owner", s_tag, 1);
    retire(0);
    req(3, 3, 16'h0100, 1'b0);
    chk("R6 other owner still busy", s_iv, 0);
    req(3, 3, 16'h0001, 1'b0);
    chk("R6 retired bits free", s_iv, 1);
    retire(0); retire(1);
  endtask

  task automatic t_same_cycle;
    req(4, 4, 16'h0001, 1'b0);
    step(1'b1, 4, 4, 16'h0001, 1'b0, 1'b1, 0);
    chk("R7 retire before check", s_iv, 1);
    chk("R7 freed tag reused", s_tag, 0);
    req(4, 4, 16'h0001, 1'b0);
    chk("R7 new marking kept", s_iv, 0);
    retire(0);
  endtask

  task automatic t_tags;
    for (int i = 0; i < 8; i++) begin
      req(i, 5, 16'h0001, 1'b0);
      chk("R11 distinct cells issue", s_iv, 1);
      chk("R9 tag order", s_tag, i);
    end
    req(0, 6, 16'h0001, 1'b0);
    chk("R9 stall when tags exhausted", s_rdy, 0);
    retire(3);
    req(0, 6, 16'h0001, 1'b0);
    chk("R9 freed tag used", s_tag, 3);
    for (int i = 0; i < 8; i++) retire(i);
  endtask

  task automatic t_ghost;
    req(5, 5, 16'h0001, 1'b0);
    retire(5);
    req(5, 5, 16'h0001, 1'b0);
    chk("R10 ghost retire ignored", s_iv, 0);
    req(5, 5, 16'h0002, 1'b0);
    chk("R10 tag 5 not freed early", s_tag, 1);
    retire(0); retire(1);
    req(5, 5, 16'h0003, 1'b0);
    chk("R6 all cleared", s_iv, 1);
    retire(0);
  endtask

  initial begin
    #(8 * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #3;
    chk("R1 ready in reset", in_ready, 1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_conflict();
    t_sample_share();
    t_pixel();
    t_partial_retire();
    t_same_cycle();
    t_tags();
    t_ghost();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule